// File: doc/BRIEF.md
# Descriptor Chain Walker

This block runs a list of transfer descriptors that software has laid out in memory. Software writes the byte address of the first descriptor to a start register. The walker reads that descriptor one 32-bit word at a time over a simple request/acknowledge read port. It then presents the descriptor's fields to an attached transfer engine and waits for the engine to report completion. After that it moves on to the descriptor named by the link word. The chain ends when a link of all ones is read.

Each descriptor is eight words long. Byte offset 0x00 through 0x18 hold source, destination, length, command, source key slot, IV address and block size. Offset 0x1C holds the link. The walker always shows the address of the descriptor it is working on. After any failure it leaves that address in place so software can find the descriptor that broke the chain. Status reports busy, aborted, a descriptor error and an engine error. Writing zero to the control register stops a running chain at the next safe point.

Top module: `chain_walker`

## Requirements
- R1: A descriptor is fetched as eight single-word reads at addresses base+0, +4, …, +28. Word k (k = 0..6) drives, in order, xfer_src, xfer_dst, xfer_len, xfer_cmd, xfer_key, xfer_iv and xfer_blk. Word 7 is the link. A read request holds its address until it is acknowledged.
- R2: While idle, a write to register offset 0x20 loads cur_desc with the written address and starts fetching there. The same write clears aborted, tag_err and exec_err.
- R3: When a descriptor whose link is 0xFFFFFFFF completes, busy drops with aborted clear and no further read is issued.
- R4: Descriptors run strictly in sequence. No read request is made while xfer_valid is high, and the next fetch starts only after xfer_done.
- R5: While a descriptor is being fetched or executed, cur_desc equals its address, and it stays stable while xfer_valid waits for done.
- R6: A read acknowledged with mem_err sets tag_err and aborted, ends the chain, and leaves cur_desc at the failing descriptor.
- R7: A start address or link whose two low bits are not zero sets tag_err and aborted, loads cur_desc with that address, and issues no read.
- R8: xfer_err together with xfer_done sets exec_err and aborted and ends the chain with no further read.
- R9: Writing 0 to register offset 0x1C during a chain lets the current read beat or the current transfer finish, then ends the chain with aborted set.
- R10: busy is high from the start write until the chain terminates or aborts. A start write while busy is ignored.
- R11: After reset, busy, aborted, tag_err, exec_err, mem_req and xfer_valid are 0 and cur_desc is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset (0x20 start, 0x1C control) |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Chain in progress |
| aborted | output | 1 | Last chain ended abnormally |
| tag_err | output | 1 | Descriptor fetch or alignment error |
| exec_err | output | 1 | Transfer engine reported an error |
| cur_desc | output | 32 | Address of the current descriptor |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read byte address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_err | input | 1 | Read bus error, qualified by mem_ack |
| mem_rdata | input | 32 | Read data |
| xfer_valid | output | 1 | Descriptor fields valid for the engine |
| xfer_src | output | 32 | Source address field |
| xfer_dst | output | 32 | Destination address field |
| xfer_len | output | 32 | Length field |
| xfer_cmd | output | 32 | Command field |
| xfer_key | output | 32 | Source key slot field |
| xfer_iv | output | 32 | IV address field |
| xfer_blk | output | 32 | Block size field |
| xfer_done | input | 1 | Engine finished the transfer |
| xfer_err | input | 1 | Engine error, qualified by xfer_done |

## Verification
The bench checks a misaligned link that appears only after a good descriptor. A walker that tested only the start address would fetch from the bad address, and one that left cur_desc at the previous descriptor would hide the culprit. It also injects a read error on the third word of a second descriptor. A design that ignored mem_err would run garbage fields or keep walking. The bench also checks a stop written mid-fetch, which must end the chain with no transfer issued, and a start written while busy, which must not redirect the chain. An engine error must stop the fetch count at exactly one descriptor.

// File: rtl/chain_walker.sv
module chain_walker #(
  parameter logic [7:0]  START_OFS = 8'h20,
  parameter logic [7:0]  CTRL_OFS  = 8'h1C,
  parameter logic [31:0] TERM      = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic        busy,
  output logic        aborted,
  output logic        tag_err,
  output logic        exec_err,
  output logic [31:0] cur_desc,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  output logic        xfer_valid,
  output logic [31:0] xfer_src,
  output logic [31:0] xfer_dst,
  output logic [31:0] xfer_len,
  output logic [31:0] xfer_cmd,
  output logic [31:0] xfer_key,
  output logic [31:0] xfer_iv,
  output logic [31:0] xfer_blk,
  input  logic        xfer_done,
  input  logic        xfer_err
);
  localparam int NW = 8;
  localparam int IW = $clog2(NW);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC} st_t;

  st_t              st;
  logic [IW-1:0]    idx;
  logic [31:0]      fld [NW];
  logic             stop_pend;

  wire start_wr = reg_we && (reg_addr == START_OFS);
  wire stop_wr  = reg_we && (reg_addr == CTRL_OFS) && (reg_wdata == 32'd0);
  wire stop_now = stop_pend || stop_wr;

  assign busy       = (st != S_IDLE);
  assign mem_req    = (st == S_FETCH);
  assign mem_addr   = cur_desc + {{(32-IW-2){1'b0}}, idx, 2'b00};
  assign xfer_valid = (st == S_EXEC);
  assign xfer_src   = fld[0];
  assign xfer_dst   = fld[1];
  assign xfer_len   = fld[2];
  assign xfer_cmd   = fld[3];
  assign xfer_key   = fld[4];
  assign xfer_iv    = fld[5];
  assign xfer_blk   = fld[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      stop_pend <= 1'b0;
      aborted   <= 1'b0;
      tag_err   <= 1'b0;
      exec_err  <= 1'b0;
      cur_desc  <= '0;
      for (int i = 0; i < NW; i++) fld[i] <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start_wr) begin
            cur_desc  <= reg_wdata;
            idx       <= '0;
            stop_pend <= 1'b0;
            exec_err  <= 1'b0;
            if (reg_wdata[1:0] != 2'b00) begin
              tag_err <= 1'b1;
              aborted <= 1'b1;
            end else begin
              tag_err <= 1'b0;
              aborted <= 1'b0;
              st      <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (stop_wr) stop_pend <= 1'b1;
          if (mem_ack) begin
            if (mem_err) begin
              tag_err <= 1'b1;
              aborted <= 1'b1;
              st      <= S_IDLE;
            end else begin
              fld[idx] <= mem_rdata;
              idx      <= idx + 1'b1;
              if (stop_now) begin
                aborted <= 1'b1;
                st      <= S_IDLE;
              end else if (idx == IW'(NW-1)) begin
                st <= S_EXEC;
              end
            end
          end
        end
        S_EXEC: begin
          if (stop_wr) stop_pend <= 1'b1;
          if (xfer_done) begin
            if (xfer_err) begin
              exec_err <= 1'b1;
              aborted  <= 1'b1;
              st       <= S_IDLE;
            end else if (stop_now) begin
              aborted <= 1'b1;
              st      <= S_IDLE;
            end else if (fld[NW-1] == TERM) begin
              st <= S_IDLE;
            end else begin
              cur_desc <= fld[NW-1];
              idx      <= '0;
              if (fld[NW-1][1:0] != 2'b00) begin
                tag_err <= 1'b1;
                aborted <= 1'b1;
                st      <= S_IDLE;
              end else begin
                st <= S_FETCH;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R1
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start_wr |=> cur_desc == $past(reg_wdata)); // R2
  AST_DONE_NO_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_done |=> !xfer_valid); // R4
  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_done |=> xfer_valid && $stable(xfer_src) && $stable(cur_desc)); // R5
  AST_FETCH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> !busy && tag_err && aborted && $stable(cur_desc)); // R6
  AST_EXEC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_done && xfer_err |=> !busy && exec_err && aborted); // R8
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aborted) |-> !busy); // R9
endmodule

// File: tb/chain_walker_tb.sv
module chain_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        busy, aborted, tag_err, exec_err;
  logic [31:0] cur_desc;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        xfer_valid;
  logic [31:0] xfer_src, xfer_dst, xfer_len, xfer_cmd, xfer_key, xfer_iv, xfer_blk;
  logic        xfer_done = 1'b0, xfer_err = 1'b0;

  always #5 clk = ~clk;

  chain_walker u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(busy), .aborted(aborted), .tag_err(tag_err), .exec_err(exec_err), .cur_desc(cur_desc),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .xfer_valid(xfer_valid), .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_len(xfer_len),
    .xfer_cmd(xfer_cmd), .xfer_key(xfer_key), .xfer_iv(xfer_iv), .xfer_blk(xfer_blk),
    .xfer_done(xfer_done), .xfer_err(xfer_err)
  );

  logic [31:0] mem [0:127];
  localparam logic [31:0] ERR_ADDR = 32'h0C8;
  int fetches = 0;
  int nlog = 0;
  int eng_cnt = 0;
  int overlap = 0;
  logic inject_err = 1'b0;
  logic [31:0] log_cur [0:7];
  logic [31:0] log_f [0:7][0:6];
  int checks = 0, fails = 0;

  function automatic logic [31:0] pat(input logic [31:0] base, input int k);
    return {4'hA, 4'(k), 8'h00, base[15:0]};
  endfunction

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    mem_err <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[8:2]];
      mem_err   <= (mem_addr == ERR_ADDR);
      fetches   <= fetches + 1;
    end
  end

  always @(posedge clk) begin
    xfer_done <= 1'b0;
    xfer_err  <= 1'b0;
    if (xfer_valid && !xfer_done) begin
      if (eng_cnt == 0) begin
        log_cur[nlog % 8]  <= cur_desc;
        log_f[nlog % 8][0] <= xfer_src;
        log_f[nlog % 8][1] <= xfer_dst;
        log_f[nlog % 8][2] <= xfer_len;
        log_f[nlog % 8][3] <= xfer_cmd;
        log_f[nlog % 8][4] <= xfer_key;
        log_f[nlog % 8][5] <= xfer_iv;
        log_f[nlog % 8][6] <= xfer_blk;
        nlog <= nlog + 1;
      end
      if (eng_cnt == 2) begin
        xfer_done <= 1'b1;
        xfer_err  <= inject_err;
        eng_cnt   <= 0;
      end else begin
        eng_cnt <= eng_cnt + 1;
      end
    end
  end

  always @(negedge clk) if (mem_req && xfer_valid) overlap <= overlap + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    repeat (2) @(negedge clk);
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (busy) begin
      checks++; fails++;
      $display("FAIL R10 watchdog actual=busy expected=idle");
    end
  endtask

  task automatic fill(input logic [31:0] base, input logic [31:0] nxt);
    for (int k = 0; k < 7; k++) mem[base[8:2] + 7'(k)] = pat(base, k);
    mem[base[8:2] + 7'd7] = nxt;
  endtask

  // start, count, stride, fetches, aborted, tag_err, exec_err, final cur_desc
  localparam logic [31:0] TV [5][8] = '{
    '{32'h000, 3, 32'h40, 24, 0, 0, 0, 32'h080},
    '{32'h100, 1, 32'h00,  8, 0, 0, 0, 32'h100},
    '{32'h140, 1, 32'h00,  8, 1, 1, 0, 32'h182},
    '{32'h1C0, 1, 32'h00, 11, 1, 1, 0, 32'h0C0},
    '{32'h102, 0, 32'h00,  0, 1, 1, 0, 32'h102}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n0, f0;
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    fill(32'h000, 32'h040);
    fill(32'h040, 32'h080);
    fill(32'h080, 32'hFFFF_FFFF);
    fill(32'h0C0, 32'hFFFF_FFFF);
    fill(32'h100, 32'hFFFF_FFFF);
    fill(32'h140, 32'h182);
    fill(32'h1C0, 32'h0C0);

    repeat (3) @(negedge clk);
    check("R11 busy", 32'(busy), 0);
    check("R11 aborted", 32'(aborted), 0);
    check("R11 errors", {30'd0, tag_err, exec_err}, 0);
    check("R11 cur_desc", cur_desc, 0);
    check("R11 idle ports", {30'd0, mem_req, xfer_valid}, 0);
    rst_n = 1'b1;

    for (int r = 0; r < 5; r++) begin
      n0 = nlog; f0 = fetches;
      reg_write(8'h20, TV[r][0]);
      wait_idle();
      check("R3/R6/R7/R8 count", 32'(nlog - n0), TV[r][1]);
      check("R1 fetch count", 32'(fetches - f0), TV[r][3]);
      check("R6/R7 aborted", 32'(aborted), TV[r][4]);
      check("R6/R7 tag_err", 32'(tag_err), TV[r][5]);
      check("R8 exec_err", 32'(exec_err), TV[r][6]);
      check("R5/R7 cur_desc", cur_desc, TV[r][7]);
      for (int i = 0; i < int'(TV[r][1]); i++) begin
        check("R2/R5 descriptor address", log_cur[(n0 + i) % 8], TV[r][0] + 32'(i) * TV[r][2]);
        for (int k = 0; k < 7; k++)
          check("R1 field", log_f[(n0 + i) % 8][k], pat(log_cur[(n0 + i) % 8], k));
      end
    end

    // R8: engine error stops after the first descriptor
    inject_err = 1'b1;
    n0 = nlog; f0 = fetches;
    reg_write(8'h20, 32'h000);
    wait_idle();
    inject_err = 1'b0;
    check("R8 count", 32'(nlog - n0), 1);
    check("R8 no next fetch", 32'(fetches - f0), 8);
    check("R8 status", {29'd0, aborted, tag_err, exec_err}, 32'b101);
    check("R8 cur_desc", cur_desc, 32'h000);

    // R2: new start clears previous error status
    reg_write(8'h20, 32'h100);
    wait_idle();
    check("R2 status cleared", {29'd0, aborted, tag_err, exec_err}, 0);

    // R9: stop mid-fetch
    n0 = nlog;
    reg_write(8'h20, 32'h000);
    check("R10 busy after start", 32'(busy), 1);
    @(negedge clk);
    reg_write(8'h1C, 32'h0);
    wait_idle();
    check("R9 no transfer", 32'(nlog - n0), 0);
    check("R9 aborted", 32'(aborted), 1);
    check("R9 no error bits", {30'd0, tag_err, exec_err}, 0);

    // R10: start while busy ignored
    n0 = nlog;
    reg_write(8'h20, 32'h000);
    repeat (3) @(negedge clk);
    reg_write(8'h20, 32'h100);
    wait_idle();
    check("R10 chain not redirected", 32'(nlog - n0), 3);
    check("R10 final cur_desc", cur_desc, 32'h080);
    check("R3 clean end", 32'(aborted), 0);

    check("R4 no fetch during transfer", 32'(overlap), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule